// File: doc/BRIEF.md
# FM Read-Pulse Data Separator

This block takes the stream of read pulses recovered from a single-density (FM) recording and sorts each pulse into one of two outputs: a separated-clock strobe and a separated-data strobe. In FM every 4 µs bit cell starts with a clock pulse and may carry a data pulse near its middle. The separator alternates between a clock window and a data window. A clock pulse opens the data window, and the data window then times out back to the clock window. The data window is a little shorter when the previous cell carried data and a little longer when it did not. This compensates for the peak shift that neighbouring flux changes cause.

The read pulse enters already synchronized to the system clock. All windows are counted in system clocks, and with a 20 MHz clock the windows are 58 and 62 cycles long. Separation runs only while the head is loaded and the write gate is off. Dropping either condition puts the separator back into its start-up state. A byte deserializer placed downstream consumes the two strobes.

Top module: `fm_data_separator`

## Requirements
- R1: After reset the clock window is open with no time limit, so the first rising edge of `readPulse` gives a one-cycle `sepClock` in the cycle after the edge where the high level is first sampled.
- R2: After a cell without data, the data window accepts a pulse whose rising edge is sampled 1 to LONG_WIN (62) cycles after the clock edge and outputs it as `sepData`. A pulse at offset 63 is output as `sepClock` instead.
- R3: After a cell that held data, the data window covers offsets 1 to SHORT_WIN (58) only. A pulse at offset 59 is output as `sepClock`.
- R4: A pulse accepted in the data window is marked as data for its cell. The mark is cleared by the next `sepClock`, so a following cell with no pulse counts as a cell without data.
- R5: When the data window closes, the data mark of the cell just ended selects the next window length. Data gives the short window and no data gives the long window.
- R6: If a data pulse is still high when the window length expires, `dataWinOpen` stays 1 until the cycle after `readPulse` is sampled low, and then it drops.
- R7: While `headLoaded` is 0 or `writeGate` is 1, pulses give no strobes and `dataWinOpen` is 0. On re-enable the clock window is open and the next window is the long one.
- R8: A second rising edge inside one data window gives no strobe and increments `errCount` by one. The counter saturates at its maximum.
- R9: `sepClock` and `sepData` are each one cycle wide and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (20 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| headLoaded | input | 1 | Head is loaded; needed for separation |
| writeGate | input | 1 | Write in progress; separation paused while 1 |
| readPulse | input | 1 | Synchronized combined read-pulse level |
| sepClock | output | 1 | One-cycle strobe for a separated clock pulse |
| sepData | output | 1 | One-cycle strobe for a separated data pulse |
| dataWinOpen | output | 1 | High while the data window is open |
| errCount | output | ERR_W | Saturating count of dropped extra pulses |

## Verification
Two things can fall on the same cycle: a data pulse arriving in the last counted cycle of the window, and the window timing out. The bench provokes this with pulses at exactly offset 58 (short window) and offset 62 (long window). Each must come out as data, and the next pulse a couple of cycles later must come out as clock. A pulse held high across the expiry point covers the second case, and the bench checks that `dataWinOpen` tracks the falling edge of the pulse rather than the counter.

// File: rtl/fmsep_pkg.sv
package fmsep_pkg;

  typedef enum logic {
    PH_CLOCK = 1'b0,
    PH_DATA  = 1'b1
  } sepPhase_t;

  typedef struct packed {
    logic clear;      // separator disabled: return to start-up state
    logic count;      // data window active this cycle
    logic takeClock;  // accept a pulse as clock, open the data window
    logic takeData;   // accept a pulse as data
    logic closeData;  // data window ends at this edge
    logic flagErr;    // extra pulse inside one window
  } sepCtrl_t;

endpackage

// File: rtl/fmsep_datapath.sv
module fmsep_datapath
  import fmsep_pkg::*;
#(
  parameter int SHORT_WIN = 58,
  parameter int LONG_WIN  = 62,
  parameter int ERR_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  sepCtrl_t         ctrl,
  output logic             winDone,
  output logic             latchSet,
  output logic             sepClock,
  output logic             sepData,
  output logic [ERR_W-1:0] errCount
);

  localparam int CNT_W = $clog2(LONG_WIN + 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_WIN - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_WIN - 1);
  localparam logic [CNT_W-1:0] CNT_MAX    = '1;
  localparam logic [ERR_W-1:0] ERR_MAX    = '1;

  logic [CNT_W-1:0] winCnt;
  logic             dataMark;
  logic             prevHadData;
  logic [CNT_W-1:0] winLast;

  // Window length picked by what the previous cell held
  assign winLast  = prevHadData ? SHORT_LAST : LONG_LAST;
  assign winDone  = (winCnt >= winLast);
  assign latchSet = dataMark;

  // Cycle counter inside the data window, saturating while a pulse holds it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      winCnt <= '0;
    end else if (ctrl.clear || ctrl.takeClock) begin
      winCnt <= '0;
    end else if (ctrl.count && (winCnt != CNT_MAX)) begin
      winCnt <= winCnt + 1'b1;
    end
  end

  // Per-cell data mark and the history bit copied at window close
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dataMark    <= 1'b0;
      prevHadData <= 1'b0;
    end else if (ctrl.clear) begin
      dataMark    <= 1'b0;
      prevHadData <= 1'b0;
    end else begin
      if (ctrl.takeClock)     dataMark <= 1'b0;
      else if (ctrl.takeData) dataMark <= 1'b1;
      if (ctrl.closeData)     prevHadData <= dataMark;
    end
  end

  // Registered output strobes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sepClock <= 1'b0;
      sepData  <= 1'b0;
    end else begin
      sepClock <= ctrl.takeClock & ~ctrl.clear;
      sepData  <= ctrl.takeData & ~ctrl.clear;
    end
  end

  // Saturating count of dropped pulses; kept across enable changes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      errCount <= '0;
    end else if (ctrl.flagErr && (errCount != ERR_MAX)) begin
      errCount <= errCount + 1'b1;
    end
  end

endmodule

// File: rtl/fmsep_control.sv
module fmsep_control
  import fmsep_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     enable,
  input  logic     readPulse,
  input  logic     winDone,
  input  logic     latchSet,
  output sepCtrl_t ctrl,
  output logic     dataWinOpen
);

  sepPhase_t phase;
  logic      prevPulse;
  logic      pulseRise;
  logic      inData;
  logic      holdOpen;

  assign inData    = (phase == PH_DATA);
  assign pulseRise = enable & readPulse & ~prevPulse;

  always_comb begin
    ctrl           = '0;
    ctrl.clear     = ~enable;
    ctrl.count     = enable & inData;
    ctrl.takeClock = pulseRise & ~inData;
    ctrl.takeData  = pulseRise & inData & ~latchSet;
    ctrl.flagErr   = pulseRise & inData & latchSet;
    // A data pulse that began in this window keeps it open while high
    holdOpen       = readPulse & (latchSet | ctrl.takeData);
    ctrl.closeData = enable & inData & winDone & ~holdOpen;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevPulse <= 1'b0;
    end else begin
      prevPulse <= readPulse;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_CLOCK;
    end else if (ctrl.clear) begin
      phase <= PH_CLOCK;
    end else if (ctrl.takeClock) begin
      phase <= PH_DATA;
    end else if (ctrl.closeData) begin
      phase <= PH_CLOCK;
    end
  end

  assign dataWinOpen = inData;

endmodule

// File: rtl/fm_data_separator.sv
module fm_data_separator
  import fmsep_pkg::*;
#(
  parameter int SHORT_WIN = 58,
  parameter int LONG_WIN  = 62,
  parameter int ERR_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             headLoaded,
  input  logic             writeGate,
  input  logic             readPulse,
  output logic             sepClock,
  output logic             sepData,
  output logic             dataWinOpen,
  output logic [ERR_W-1:0] errCount
);

  sepCtrl_t ctrl;
  logic     winDone;
  logic     latchSet;
  logic     enable;

  assign enable = headLoaded & ~writeGate;

  fmsep_control u_control (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .readPulse   (readPulse),
    .winDone     (winDone),
    .latchSet    (latchSet),
    .ctrl        (ctrl),
    .dataWinOpen (dataWinOpen)
  );

  fmsep_datapath #(
    .SHORT_WIN (SHORT_WIN),
    .LONG_WIN  (LONG_WIN),
    .ERR_W     (ERR_W)
  ) u_datapath (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl     (ctrl),
    .winDone  (winDone),
    .latchSet (latchSet),
    .sepClock (sepClock),
    .sepData  (sepData),
    .errCount (errCount)
  );

endmodule

// File: rtl/fm_data_separator_chk.sv
module fm_data_separator_chk #(
  parameter int ERR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             headLoaded,
  input logic             writeGate,
  input logic             readPulse,
  input logic             sepClock,
  input logic             sepData,
  input logic             dataWinOpen,
  input logic [ERR_W-1:0] errCount
);

  logic enableChk;
  assign enableChk = headLoaded & ~writeGate;

  p_strobe_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(sepClock && sepData));

  p_clock_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sepClock |=> !sepClock);

  p_data_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sepData |=> !sepData);

  p_clock_opens_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sepClock |-> dataWinOpen);

  p_clock_from_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sepClock |-> ($past(readPulse) && $past(enableChk)));

  p_data_in_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sepData |-> dataWinOpen);

  p_hold_while_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sepData && readPulse && enableChk) |=> dataWinOpen);

  p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !enableChk |=> (!sepClock && !sepData && !dataWinOpen));

  p_err_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(errCount) |-> (errCount == ERR_W'($past(errCount) + 1'b1)));

endmodule

bind fm_data_separator fm_data_separator_chk #(.ERR_W(ERR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .headLoaded  (headLoaded),
  .writeGate   (writeGate),
  .readPulse   (readPulse),
  .sepClock    (sepClock),
  .sepData     (sepData),
  .dataWinOpen (dataWinOpen),
  .errCount    (errCount)
);

// File: tb/fm_data_separator_bench.sv
module fm_data_separator_bench;

  localparam int CLK_PERIOD = 50;
  localparam int ERR_W      = 8;
  localparam int NV         = 19;

  // gap = cycles from the previous rising edge to this one
  localparam int    VGAP[NV] = '{10, 62, 2, 58, 3, 59, 61, 4, 10, 10,
                                  40, 30, 29, 60, 60, 3, 59, 63, 62};
  localparam bit    VCLK[NV] = '{1, 0, 1, 0, 1, 1, 0, 1, 0, 0,
                                 1, 0, 1, 1, 0, 1, 1, 1, 0};
  localparam bit    VDAT[NV] = '{0, 1, 0, 1, 0, 0, 1, 0, 1, 0,
                                 0, 1, 0, 0, 1, 0, 0, 0, 1};
  localparam bit    VERR[NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 1,
                                 0, 0, 0, 0, 0, 0, 0, 0, 0};
  localparam string VREQ[NV] = '{"R1", "R2", "R5", "R3", "R4", "R3", "R5", "R4", "R4", "R8",
                                 "R3", "R4", "R3", "R4", "R2", "R5", "R3", "R2", "R2"};

  logic             clk = 1'b0;
  logic             rst_n;
  logic             headLoaded;
  logic             writeGate;
  logic             readPulse;
  logic             sepClock;
  logic             sepData;
  logic             dataWinOpen;
  logic [ERR_W-1:0] errCount;

  int applied = 0;
  int fails   = 0;
  int expErr  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fm_data_separator #(.ERR_W(ERR_W)) u_fm_data_separator (
    .clk         (clk),
    .rst_n       (rst_n),
    .headLoaded  (headLoaded),
    .writeGate   (writeGate),
    .readPulse   (readPulse),
    .sepClock    (sepClock),
    .sepData     (sepData),
    .dataWinOpen (dataWinOpen),
    .errCount    (errCount)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    applied++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Rising edge sampled gap cycles after the previous one, one cycle high
  task automatic pulseGap(input int gap);
    repeat (gap - 1) @(negedge clk);
    readPulse = 1'b1;
    @(negedge clk);
    readPulse = 1'b0;
  endtask

  task automatic disableBriefly();
    @(negedge clk);
    headLoaded = 1'b0;
    @(negedge clk);
    headLoaded = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end

  initial begin
    rst_n      = 1'b0;
    headLoaded = 1'b1;
    writeGate  = 1'b0;
    readPulse  = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "reset sepClock", int'(sepClock), 0);
    check("R1", "reset sepData", int'(sepData), 0);
    check("R1", "reset dataWinOpen", int'(dataWinOpen), 0);
    check("R8", "reset errCount", int'(errCount), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      pulseGap(VGAP[i]);
      expErr += int'(VERR[i]);
      check(VREQ[i], $sformatf("vec%0d sepClock", i), int'(sepClock), int'(VCLK[i]));
      check(VREQ[i], $sformatf("vec%0d sepData", i), int'(sepData), int'(VDAT[i]));
      check(VREQ[i], $sformatf("vec%0d errCount", i), int'(errCount), expErr);
    end

    // R7: write gate active blocks pulses and closes the window
    @(negedge clk);
    writeGate = 1'b1;
    pulseGap(3);
    check("R7", "writeGate sepClock", int'(sepClock), 0);
    check("R7", "writeGate sepData", int'(sepData), 0);
    check("R7", "writeGate dataWinOpen", int'(dataWinOpen), 0);
    writeGate = 1'b0;
    headLoaded = 1'b0;
    pulseGap(3);
    check("R7", "unloaded sepClock", int'(sepClock), 0);
    check("R7", "unloaded dataWinOpen", int'(dataWinOpen), 0);
    headLoaded = 1'b1;
    @(negedge clk);
    // Re-enabled: clock window open, long window next
    pulseGap(5);
    check("R7", "re-enable first pulse clock", int'(sepClock), 1);
    pulseGap(61);
    check("R7", "re-enable long window data", int'(sepData), 1);
    check("R7", "disabled pulses not counted", int'(errCount), expErr);

    // R6: data pulse held high past the window end
    disableBriefly();
    pulseGap(5);
    check("R6", "hold setup clock", int'(sepClock), 1);
    repeat (59) @(negedge clk);
    readPulse = 1'b1;                      // rise sampled at offset 60
    @(negedge clk);
    check("R6", "held pulse is data", int'(sepData), 1);
    repeat (6) @(negedge clk);
    check("R6", "window open at offset 66", int'(dataWinOpen), 1);
    @(negedge clk);
    readPulse = 1'b0;
    check("R6", "window open at offset 67", int'(dataWinOpen), 1);
    @(negedge clk);
    check("R6", "window closed after pulse fell", int'(dataWinOpen), 0);

    // R9: strobe lasts one cycle
    pulseGap(3);
    check("R9", "clock strobe high", int'(sepClock), 1);
    check("R9", "no data with clock", int'(sepData), 0);
    @(negedge clk);
    check("R9", "clock strobe one cycle", int'(sepClock), 0);

    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end

endmodule